// File: doc/BRIEF.md
# Serial-Addressed Byte RAM with I2C Slave Port

This block is a 256 x 8 memory that a host can reach only over a two-wire I2C bus, where the block acts as a slave. Both bus lines first go through a two-flop synchroniser and then a three-sample majority filter, all on the system clock. START and STOP conditions are detected on the filtered lines. The block drives SDA through an open-drain pull-down enable. The 7-bit slave address is a fixed 4-bit device code followed by three strap inputs. Up to eight copies can therefore share one bus.

A write transaction works as follows. The first byte after the address loads an internal word pointer. Every later byte is stored at the pointer, and the pointer then advances. A read transaction returns bytes starting at the pointer and advances it after each byte. The pointer is a single register. It keeps its value across STOP and repeated START. A host can therefore write only a word address, issue a repeated START with the read bit set, and stream data from that location. The pointer wraps from 255 to 0.

Top module: `i2c_byte_ram`

## Requirements
- R1: After reset the pull-down enable is low and the word pointer is 0. Memory contents are not cleared by reset.
- R2: The address byte is the first byte after a START. Its bits [7:1] are matched against {DEV_ID (default 4'b1010), strap_i}, and bit 0 is R/W (0 = write, 1 = read). On a match the block pulls SDA low during the ninth clock.
- R3: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Either one in the middle of a byte abandons that byte without a memory write and without a pointer change. A START always begins a new address phase.
- R4: In a write, the byte after the address loads the pointer. Each later byte is stored at the pointer. Every received byte of a matched write is acknowledged with SDA low during its ninth clock.
- R5: A read sends the byte at the pointer, most significant bit first. The pointer is kept across repeated START and across STOP.
- R6: The pointer increments by one after every data byte stored or sent, and wraps from 255 to 0.
- R7: If the master leaves SDA high in the ninth clock of a read byte, the block releases SDA. It then keeps SDA released for any further clocks until the next START.
- R8: An address byte that does not match gets no acknowledge. Bytes that follow it, up to the next START, change neither the memory nor the pointer.
- R9: The block changes its SDA pull-down only while SCL is low.
- R10: A pulse of one system-clock sample on SCL or on SDA is removed by the majority filter. Such a pulse creates no clock edge, no START and no STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Low three bits of the slave address |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |

## Verification
A wrong pointer shows up at the ports in the first byte of the next read: every byte read back must equal the value that was computed for its location. The checks therefore end each write or aborted transaction with a read, including reads across the 255-to-0 wrap and a read straight after reset. A wrong state in the byte framing shows up within one byte time, as a missing or extra acknowledge or as SDA being pulled during clocks that must stay released. The bench samples SDA twice in each SCL high phase so that a drive change at the wrong time is also caught.

// File: rtl/i2c_byte_ram.sv
module i2c_byte_ram #(
  parameter logic [3:0] DEV_ID = 4'b1010,
  parameter int         WORDS  = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_pull_o
);
  localparam int AW = $clog2(WORDS);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AACK, S_WADR, S_WDAT, S_RDAT} st_t;

  logic [1:0] scl_s, sda_s;
  logic [2:0] scl_h, sda_h;
  logic       scl_f, sda_f, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1; scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_h <= {scl_h[1:0], scl_s[1]};
      sda_h <= {sda_h[1:0], sda_s[1]};
      scl_f <= (scl_h[0] & scl_h[1]) | (scl_h[0] & scl_h[2]) | (scl_h[1] & scl_h[2]);
      sda_f <= (sda_h[0] & sda_h[1]) | (sda_h[0] & sda_h[2]) | (sda_h[1] & sda_h[2]);
      scl_p <= scl_f;
      sda_p <= sda_f;
    end

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_f & ~scl_p;
  assign scl_fall = ~scl_f & scl_p;
  assign start_c  = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_c   = scl_f & scl_p & ~sda_p & sda_f;

  st_t         st;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg, txreg;
  logic [AW-1:0] ptr;
  logic        rw, mack;
  logic [7:0]  mem [WORDS];
  logic        mem_we;

  assign mem_we = scl_fall && bitcnt == 4'd8 && st == S_WDAT && !start_c && !stop_c;

  always_ff @(posedge clk)
    if (mem_we) mem[ptr] <= shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; shreg <= '0; txreg <= '0;
      ptr <= '0; rw <= 1'b0; mack <= 1'b0; sda_pull_o <= 1'b0;
    end else if (start_c) begin
      st <= S_DEV; bitcnt <= '0; sda_pull_o <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; bitcnt <= '0; sda_pull_o <= 1'b0;
    end else if (st != S_IDLE) begin
      if (scl_rise && bitcnt != 4'd9) begin
        if (bitcnt < 4'd8) shreg <= {shreg[6:0], sda_f};
        else mack <= ~sda_f;
        bitcnt <= bitcnt + 4'd1;
      end else if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          case (st)
            S_DEV:
              if (shreg[7:1] == {DEV_ID, strap_i}) begin
                sda_pull_o <= 1'b1; st <= S_AACK; rw <= shreg[0];
              end else st <= S_IDLE;
            S_WADR: begin ptr <= shreg[AW-1:0]; sda_pull_o <= 1'b1; st <= S_WDAT; end
            S_WDAT: begin ptr <= ptr + 1'b1; sda_pull_o <= 1'b1; end
            S_RDAT: begin ptr <= ptr + 1'b1; sda_pull_o <= 1'b0; end
            default: ;
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          sda_pull_o <= 1'b0;
          if ((st == S_AACK && rw) || (st == S_RDAT && mack)) begin
            st <= S_RDAT;
            txreg <= mem[ptr];
            sda_pull_o <= ~mem[ptr][7];
          end else if (st == S_AACK) st <= S_WADR;
          else if (st == S_RDAT) st <= S_IDLE;
        end else if (st == S_RDAT && bitcnt != 4'd0) begin
          txreg <= {txreg[6:0], 1'b0};
          sda_pull_o <= ~txreg[6];
        end
      end
    end

  // R9
  drive_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !$past(scl_f));

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr) && $past(st) != S_WADR) |-> ptr == $past(ptr) + 1'b1);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> !sda_pull_o);

  // R2
  ack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull_o) && $past(st) == S_DEV) |-> $past(shreg[7:1]) == {DEV_ID, $past(strap_i)});

  // R3
  bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd9);
endmodule

// File: tb/i2c_byte_ram_tb_top.sv
`timescale 1ns/1ps
module i2c_byte_ram_tb_top;
  localparam int Q = 8;
  localparam logic [3:0] DEVC = 4'b1010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic pull;
  wire  sda_line = sda_m & ~pull;

  always #5 clk = ~clk;

  i2c_byte_ram dut_i (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
                      .strap_i(strap), .sda_pull_o(pull));

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] model [256];
  int exp_ptr = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n = Q);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1; wq(); scl = 1; wq(); sda_m = 0; wq(); scl = 0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 0; wq(); scl = 1; wq(); sda_m = 1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack, input bit gl = 0);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      if (gl && i == 4) begin scl = 1; wq(1); scl = 0; end
      wq(); scl = 1; wq();
      if (gl && i == 3 && b[i]) begin sda_m = 0; wq(1); sda_m = 1; end
      wq(); scl = 0; wq();
    end
    sda_m = 1; wq(); scl = 1; wq();
    ack = ~sda_line;
    wq(); scl = 0; wq();
  endtask

  task automatic send_bits(input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = 0; wq(); scl = 1; wq(); wq(); scl = 0; wq();
    end
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    bit steady = 1;
    logic s1;
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      wq(); scl = 1; wq(); s1 = sda_line;
      b = {b[6:0], s1};
      wq(Q - 1);
      if (sda_line !== s1) steady = 0;
      wq(1); scl = 0;
    end
    chk(steady, "R9 drive stable in SCL high", 0, 0);
    wq(); sda_m = give_ack ? 1'b0 : 1'b1;
    wq(); scl = 1; wq(); wq(); scl = 0; wq(); sda_m = 1;
  endtask

  function automatic logic [7:0] pat(input int a, input int seed);
    return 8'((a * 37 + seed) & 255);
  endfunction

  task automatic wr_block(input int wa, input int n, input int seed, input int gl_at = -1);
    bit a;
    int nacks = 0;
    bus_start();
    send_byte({DEVC, strap, 1'b0}, a); if (!a) nacks++;
    send_byte(8'(wa), a); if (!a) nacks++;
    for (int i = 0; i < n; i++) begin
      logic [7:0] v = pat((wa + i) % 256, seed);
      send_byte(v, a, i == gl_at);
      if (!a) nacks++;
      model[(wa + i) % 256] = v;
    end
    bus_stop();
    chk(nacks == 0, "R4 write acks", nacks, 0);
    exp_ptr = (wa + n) % 256;
  endtask

  task automatic rd_body(input int n, input string tag);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      recv_byte(b, i != n - 1);
      chk(b === model[exp_ptr], tag, b, model[exp_ptr]);
      exp_ptr = (exp_ptr + 1) % 256;
    end
  endtask

  task automatic rd_at(input int wa, input int n, input string tag);
    bit a1, a2, a3;
    bus_start();
    send_byte({DEVC, strap, 1'b0}, a1);
    send_byte(8'(wa), a2);
    bus_start();
    send_byte({DEVC, strap, 1'b1}, a3);
    chk(a1 && a2 && a3, "R2 read setup acks", {a1, a2, a3}, 7);
    exp_ptr = wa;
    rd_body(n, tag);
    bus_stop();
  endtask

  task automatic rd_cur(input int n, input string tag);
    bit a;
    bus_start();
    send_byte({DEVC, strap, 1'b1}, a);
    chk(a, "R2 read address ack", a, 1);
    rd_body(n, tag);
    bus_stop();
  endtask

  initial begin
    bit a;
    logic [7:0] b;
    int zeros;
    wq(5);
    chk(pull === 1'b0, "R1 pull low after reset", pull, 0);
    rst_n = 1;
    wq(20);
    chk(pull === 1'b0, "R1 idle released", pull, 0);

    // R2: address sweep over strap bits and each device-code bit
    for (int k = 0; k < 12; k++) begin
      logic [6:0] ad = (k < 8) ? {DEVC, 3'(k)} : {DEVC ^ 4'(1 << (k - 8)), strap};
      bus_start();
      send_byte({ad, 1'b0}, a);
      bus_stop();
      chk(a == (ad == {DEVC, strap}), "R2 address match", a, ad == {DEVC, strap});
    end

    // R4, R6, R10: full memory fill starting at F0 with glitched byte
    wr_block(8'hF0, 256, 11, 5);
    rd_at(8'hF8, 16, "R6 wrap read");
    rd_cur(4, "R5 pointer kept across STOP");
    rd_at(8'hF5, 1, "R10 glitched byte");
    rd_at(8'h00, 6, "R5 read from 0");
    rd_at(8'h7F, 3, "R5 read mid");
    rd_at(8'hFF, 1, "R6 read last");
    rd_cur(2, "R6 wrap to 0 after read");

    wr_block(8'h30, 5, 200);
    rd_at(8'h2E, 9, "R4 partial write");
    wr_block(8'hFE, 3, 77);
    rd_cur(1, "R6 write wrap pointer");
    rd_at(8'hFD, 5, "R6 write wrap data");

    // R8: non-matching address, following bytes ignored
    rd_at(8'h10, 1, "R8 pre");
    bus_start();
    send_byte({4'b1011, strap, 1'b0}, a);
    chk(!a, "R8 no ack on mismatch", a, 0);
    send_byte(8'h40, a);
    chk(!a, "R8 no ack after mismatch", a, 0);
    send_byte(8'h55, a);
    bus_stop();
    rd_cur(1, "R8 pointer untouched");
    rd_at(8'h40, 1, "R8 memory untouched");

    // R3: START in the middle of a data byte aborts it
    bus_start();
    send_byte({DEVC, strap, 1'b0}, a);
    send_byte(8'h20, a);
    send_bits(4);
    bus_start();
    send_byte({DEVC, strap, 1'b1}, a);
    exp_ptr = 8'h20;
    rd_body(1, "R3 aborted byte not written");
    bus_stop();
    rd_cur(1, "R3 pointer after abort");

    // R7: master NACK releases SDA for further clocks
    bus_start();
    send_byte({DEVC, strap, 1'b0}, a);
    send_byte(8'h0F, a);
    bus_start();
    send_byte({DEVC, strap, 1'b1}, a);
    recv_byte(b, 0);
    chk(b === model[8'h0F], "R7 last byte", b, model[8'h0F]);
    zeros = 0;
    for (int i = 0; i < 9; i++) begin
      wq(); scl = 1; wq(); if (!sda_line) zeros++; wq(); scl = 0; wq();
      if (pull) zeros++;
    end
    chk(zeros == 0, "R7 released after NACK", zeros, 0);
    bus_stop();
    exp_ptr = 8'h10;
    rd_cur(1, "R7 pointer after NACK");

    // R2: strap change
    strap = 3'b010;
    bus_start(); send_byte({DEVC, 3'b010, 1'b0}, a); bus_stop();
    chk(a, "R2 new strap acked", a, 1);
    bus_start(); send_byte({DEVC, 3'b101, 1'b0}, a); bus_stop();
    chk(!a, "R2 old strap ignored", a, 0);

    // R1: reset clears pointer, keeps memory
    rst_n = 0; wq(4); rst_n = 1; wq(20);
    exp_ptr = 0;
    rd_cur(2, "R1 pointer zero after reset");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule